// File: doc/BRIEF.md
# SPI Serial Memory Slave Front End

This block is the serial front end of a byte-organized nonvolatile memory. It takes a serial clock, serial data in, an active-low select and an active-low pause input. All four are resynchronized into the system clock. Its serial output is expressed as a data bit plus an output-enable, and the enable low means high impedance. Every transaction opens with an 8-bit instruction. Three instructions are understood: a read with a 16-bit address and a data stream, a page write with a 16-bit address and data bytes, and a status register load with one data byte. Any other instruction code makes the block ignore the rest of that transaction.

Written data is only staged while the select is low. It is committed when the select rises on a byte boundary and the external `wr_permit` signal is high. A commit starts a self-timed busy interval of `WR_CYCLES` system clocks. Any transaction whose select falls inside that interval is ignored. Pulling the pause input low freezes the transaction at the current bit, and it resumes from that bit when the pause is released.

The state machine has seven states:
- ST_IDLE: select high. It leaves to ST_CMD, or to ST_SKIP if busy, when the select falls.
- ST_CMD: collects the instruction. On the eighth bit it goes to ST_ADDR for read or write, to ST_SRDATA for a status load, and to ST_SKIP for anything else.
- ST_ADDR: collects 16 address bits. It then goes to ST_RDATA for a read and to ST_WDATA for a write.
- ST_RDATA: streams data bytes.
- ST_WDATA: stages data bytes.
- ST_SRDATA: collects one status byte. Any further bit sends it to ST_SKIP.
- ST_SKIP: discards everything until the select rises.

A high select returns every state to ST_IDLE.

Top module: `spi_nvm_slave`

## Requirements
- R1: After reset, `so_oe` is 0, `busy` is 0 and `status` is 0x00.
- R2: Both serial modes work: clock idling low (mode 0) and clock idling high (mode 3). SI is taken on rising SCK, SO changes on falling SCK, and every byte travels MSB first.
- R3: Instruction 0x03, then a 16-bit address, returns the byte at the address's low log2(DEPTH) bits. Its MSB is driven on the first falling SCK after the last address bit.
- R4: During a read, the address advances by one after each byte and wraps from DEPTH-1 to 0, for as long as clocks continue.
- R5: Instruction 0x02, then a 16-bit address and N data bytes, stores byte k at the page offset (start offset + k) mod PAGE. The page bits stay unchanged, and later bytes overwrite earlier ones at the same offset.
- R6: A write is committed only if the select rises with a whole number of data bytes, at least one, received. Otherwise memory is unchanged and `busy` stays 0.
- R7: Instruction 0x01, then exactly 8 data bits, loads `status` at the select's rise. A bit count other than 8 leaves `status` unchanged.
- R8: A commit holds `busy` high for exactly WR_CYCLES clocks. A transaction whose select falls while `busy` is high is ignored: it drives no SO, writes nothing and starts no busy interval.
- R9: If `wr_permit` is low when the select rises, the write or status load is discarded and `busy` stays 0.
- R10: While the pause input is low with the select low, `so_oe` is 0 and SCK and SI have no effect. After release, shifting continues at the paused bit.
- R11: `so_oe` is 0 whenever the select is high, and during the instruction, address, write-data and status-data phases.
- R12: An instruction code other than 0x01, 0x02 or 0x03 is ignored until the select rises. No SO is driven and nothing is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock, asynchronous to clk |
| si | input | 1 | Serial data in |
| cs_n | input | 1 | Active-low select |
| hold_n | input | 1 | Active-low pause |
| wr_permit | input | 1 | Allows a commit when high at the select's rise |
| so_out | output | 1 | Serial data out value |
| so_oe | output | 1 | Serial data out enable (0 = high impedance) |
| busy | output | 1 | Self-timed write interval in progress |
| status | output | 8 | Status register contents |

## Verification
The array in the small bench configuration is written completely with page writes, alternating between the two serial modes. It is then read in full and beyond its top, so that pattern errors, address increment and wrap, and mode-dependent edge handling all show up as wrong bytes. Page writes that start mid-page or run past PAGE bytes separate page-offset wrap from plain address increment. Transactions cut mid-byte, with no data, with the permit low, with unknown codes, or begun while busy separate a commit from a discard. Pauses placed mid-byte during a read and during a write separate a true freeze from a lost or repeated bit.

// File: rtl/spim_pkg.sv
`timescale 1ns/1ps
package spim_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_CMD, ST_ADDR, ST_RDATA, ST_WDATA, ST_SRDATA, ST_SKIP
    } spim_state_e;

    localparam logic [7:0] OP_WRSR  = 8'h01;
    localparam logic [7:0] OP_WRITE = 8'h02;
    localparam logic [7:0] OP_READ  = 8'h03;
endpackage

// File: rtl/spim_sync.sv
`timescale 1ns/1ps
module spim_sync #(
    parameter int          WIDTH   = 4,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) pipe[k] <= RST_VAL;
        end else begin
            pipe[0] <= d;
            for (int k = 1; k < STAGES; k++) pipe[k] <= pipe[k-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/spim_busy.sv
`timescale 1ns/1ps
module spim_busy #(
    parameter int CYCLES = 250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(CYCLES + 1);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         cnt <= '0;
        else if (start)     cnt <= CW'(CYCLES);
        else if (cnt != '0) cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);

    // R8: a commit always opens a busy interval on the next cycle
    p_start_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);
endmodule

// File: rtl/spim_array.sv
`timescale 1ns/1ps
module spim_array #(
    parameter int DEPTH = 2048,
    parameter int PAGE  = 64
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [$clog2(DEPTH)-1:0]     rd_addr,
    output logic [7:0]                   rd_data,
    input  logic                         stg_clr,
    input  logic                         stg_we,
    input  logic [$clog2(PAGE)-1:0]      stg_idx,
    input  logic [7:0]                   stg_data,
    input  logic                         commit,
    input  logic [$clog2(DEPTH)-$clog2(PAGE)-1:0] page_base
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = $clog2(PAGE);

    logic [7:0]      mem [DEPTH];
    logic [7:0]      stg [PAGE];
    logic [PAGE-1:0] stg_v;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_v <= '0;
            for (int i = 0; i < PAGE; i++) stg[i] <= '0;
        end else if (stg_clr) begin
            stg_v <= '0;
        end else if (stg_we) begin
            stg[stg_idx]   <= stg_data;
            stg_v[stg_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int a = 0; a < DEPTH; a++) mem[a] <= '0;
        end else if (commit) begin
            for (int i = 0; i < PAGE; i++)
                if (stg_v[i]) mem[{page_base, PW'(i)}] <= stg[i];
        end
    end

    assign rd_data = mem[rd_addr];

    // R6: a commit never happens without at least one staged byte
    p_commit_staged_r6: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (stg_v != '0));

    initial begin
        assert (AW > PW) else $error("PAGE must be smaller than DEPTH");
    end
endmodule

// File: rtl/spi_nvm_slave.sv
`timescale 1ns/1ps
module spi_nvm_slave
    import spim_pkg::*;
#(
    parameter int DEPTH       = 2048,
    parameter int PAGE        = 64,
    parameter int WR_CYCLES   = 250000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sck,
    input  logic       si,
    input  logic       cs_n,
    input  logic       hold_n,
    input  logic       wr_permit,
    output logic       so_out,
    output logic       so_oe,
    output logic       busy,
    output logic [7:0] status
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = $clog2(PAGE);

    spim_state_e state, state_d;
    logic [3:0]  synced;
    logic        s_sck, s_si, s_csn, s_hold;
    logic        sck_q, csn_q;
    logic        act, sck_rise, sck_fall, cs_up, byte_done;
    logic [3:0]  bitcnt;
    logic [6:0]  sh;
    logic [7:0]  shin, srbuf, rd_data;
    logic [AW-1:0] addr;
    logic        is_read, got, drv;
    logic        wr_commit, sr_commit, start;
    logic        stg_clr, stg_we;

    spim_sync #(.WIDTH(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0011)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({sck, si, cs_n, hold_n}), .q(synced));

    assign {s_sck, s_si, s_csn, s_hold} = synced;

    assign act       = !s_csn && s_hold;
    assign sck_rise  = act && s_sck && !sck_q;
    assign sck_fall  = act && !s_sck && sck_q;
    assign cs_up     = s_csn && !csn_q;
    assign shin      = {sh, s_si};
    assign byte_done = (bitcnt[2:0] == 3'd7);

    assign wr_commit = cs_up && state == ST_WDATA  && got && bitcnt == 4'd0 && wr_permit;
    assign sr_commit = cs_up && state == ST_SRDATA && got && bitcnt == 4'd0 && wr_permit;
    assign start     = wr_commit || sr_commit;
    assign stg_clr   = sck_rise && state == ST_ADDR && bitcnt == 4'd15 && !is_read;
    assign stg_we    = sck_rise && state == ST_WDATA && byte_done;

    spim_busy #(.CYCLES(WR_CYCLES)) u_busy (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy));

    spim_array #(.DEPTH(DEPTH), .PAGE(PAGE)) u_array (
        .clk(clk), .rst_n(rst_n), .rd_addr(addr), .rd_data(rd_data),
        .stg_clr(stg_clr), .stg_we(stg_we), .stg_idx(addr[PW-1:0]),
        .stg_data(shin), .commit(wr_commit), .page_base(addr[AW-1:PW]));

    // next-state logic
    always_comb begin
        state_d = state;
        if (s_csn) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: state_d = busy ? ST_SKIP : ST_CMD;
                ST_CMD: if (sck_rise && byte_done) begin
                    if (shin == OP_READ || shin == OP_WRITE) state_d = ST_ADDR;
                    else if (shin == OP_WRSR)                state_d = ST_SRDATA;
                    else                                     state_d = ST_SKIP;
                end
                ST_ADDR:   if (sck_rise && bitcnt == 4'd15)
                               state_d = is_read ? ST_RDATA : ST_WDATA;
                ST_SRDATA: if (sck_rise && got) state_d = ST_SKIP;
                ST_RDATA, ST_WDATA, ST_SKIP: state_d = state;
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt <= '0; sh <= '0; addr <= '0; is_read <= 1'b0;
            got <= 1'b0; drv <= 1'b0; so_out <= 1'b0; status <= '0;
            srbuf <= '0; sck_q <= 1'b0; csn_q <= 1'b1;
        end else begin
            sck_q <= s_sck;
            csn_q <= s_csn;
            if (sr_commit) status <= srbuf;
            if (state == ST_IDLE) begin
                bitcnt <= '0; got <= 1'b0; drv <= 1'b0;
            end else if (sck_rise) begin
                sh <= shin[6:0];
                unique case (state)
                    ST_CMD: begin
                        bitcnt <= byte_done ? 4'd0 : bitcnt + 4'd1;
                        if (byte_done) is_read <= (shin == OP_READ);
                    end
                    ST_ADDR: begin
                        bitcnt <= bitcnt + 4'd1;
                        addr   <= {addr[AW-2:0], s_si};
                    end
                    ST_RDATA: begin
                        bitcnt <= byte_done ? 4'd0 : bitcnt + 4'd1;
                        if (byte_done) addr <= addr + 1'b1;
                    end
                    ST_WDATA: begin
                        bitcnt <= byte_done ? 4'd0 : bitcnt + 4'd1;
                        if (byte_done) begin
                            got  <= 1'b1;
                            addr <= {addr[AW-1:PW], addr[PW-1:0] + 1'b1};
                        end
                    end
                    ST_SRDATA: begin
                        bitcnt <= byte_done ? 4'd0 : bitcnt + 4'd1;
                        if (byte_done) begin
                            got   <= 1'b1;
                            srbuf <= shin;
                        end
                    end
                    default: ;
                endcase
            end else if (sck_fall && state == ST_RDATA) begin
                so_out <= rd_data[3'd7 - bitcnt[2:0]];
                drv    <= 1'b1;
            end
        end
    end

    assign so_oe = drv && s_hold && !s_csn;

    // R10: a paused transaction keeps its bit position
    p_hold_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_hold && !s_csn && state != ST_IDLE) |=> $stable(bitcnt));
    // R11: SO is only ever driven while streaming read data
    p_so_read_only_r11: assert property (@(posedge clk) disable iff (!rst_n)
        so_oe |-> state == ST_RDATA);
    // R8: no new commit can start while the previous interval runs
    p_start_not_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);
    // R2: data phases never count past one byte
    p_bit_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_ADDR) |-> (bitcnt < 4'd8));
endmodule

// File: tb/spi_nvm_slave_bench.sv
`timescale 1ns/1ps
module spi_nvm_slave_bench;
    localparam int DEPTH = 64;
    localparam int PAGE  = 8;
    localparam int WRC   = 40;
    localparam int H     = 6;

    logic clk = 1'b0, rst_n = 1'b0;
    logic sck = 1'b0, si = 1'b0, cs_n = 1'b1, hold_n = 1'b1, wr_permit = 1'b1;
    logic so_out, so_oe, busy;
    logic [7:0] status;

    int checks = 0, errors = 0;
    bit mode3 = 1'b0;
    logic [7:0] model [DEPTH];
    logic [7:0] wb [16];

    always #10 clk = ~clk;

    spi_nvm_slave #(.DEPTH(DEPTH), .PAGE(PAGE), .WR_CYCLES(WRC)) u_spi_nvm_slave (
        .clk(clk), .rst_n(rst_n), .sck(sck), .si(si), .cs_n(cs_n), .hold_n(hold_n),
        .wr_permit(wr_permit), .so_out(so_out), .so_oe(so_oe), .busy(busy), .status(status));

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bit_io(input logic b, output logic r, output logic oe);
        if (mode3) sck = 1'b0;
        si = b;
        tick(H);
        r = so_out; oe = so_oe;
        sck = 1'b1;
        tick(H);
        if (!mode3) sck = 1'b0;
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx, output logic [7:0] oev);
        for (int i = 7; i >= 0; i--) bit_io(tx[i], rx[i], oev[i]);
    endtask

    task automatic cs_lo();
        sck = mode3; tick(H); cs_n = 1'b0; tick(H);
    endtask

    task automatic cs_hi();
        tick(H); cs_n = 1'b1; tick(H);
        chk("R11 oe with select high", so_oe, 0);
    endtask

    task automatic pause();
        hold_n = 1'b0; tick(H);
        chk("R10 oe during pause", so_oe, 0);
        si = ~si; sck = ~sck; tick(H);
        si = ~si; sck = ~sck; tick(H);
        hold_n = 1'b1; tick(H);
    endtask

    task automatic finish_write(output int len);
        tick(H); cs_n = 1'b1; len = 0;
        for (int w = 0; w < 10 && !busy; w++) tick(1);
        while (busy && len < 1000) begin len++; tick(1); end
        tick(H);
    endtask

    task automatic send(input logic [7:0] tx, input string tag);
        logic [7:0] rx, oev;
        xfer(tx, rx, oev);
        chk(tag, int'(oev), 0);
    endtask

    task automatic write_page(input logic [15:0] a, input int n, input bit ok, input string tag);
        int len;
        cs_lo();
        send(8'h02, "R11 oe in instruction");
        send(a[15:8], "R11 oe in address");
        send(a[7:0], "R11 oe in address");
        for (int k = 0; k < n; k++) send(wb[k], "R11 oe in write data");
        finish_write(len);
        chk({tag, " busy length"}, len, ok ? WRC : 0);
        if (ok)
            for (int k = 0; k < n; k++)
                model[{a[5:3], 3'((a[2:0] + k) % PAGE)}] = wb[k];
    endtask

    task automatic read_seq(input logic [15:0] a, input int n, input string tag);
        logic [7:0] rx, oev;
        cs_lo();
        send(8'h03, "R11 oe in instruction");
        send(a[15:8], "R11 oe in address");
        send(a[7:0], "R11 oe in address");
        for (int k = 0; k < n; k++) begin
            xfer(8'h00, rx, oev);
            chk({tag, " data"}, rx, model[(a + k) % DEPTH]);
            chk("R3 oe in read data", oev, 8'hFF);
        end
        cs_hi();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int len;
        logic [7:0] rx, oev;
        logic r, oe;
        for (int a = 0; a < DEPTH; a++) model[a] = 8'h00;
        tick(5); rst_n = 1'b1; tick(5);
        chk("R1 so_oe", so_oe, 0);
        chk("R1 busy", busy, 0);
        chk("R1 status", status, 0);

        // R5 R2: fill every page, alternating serial modes
        for (int p = 0; p < DEPTH / PAGE; p++) begin
            mode3 = p[0];
            for (int k = 0; k < PAGE; k++) wb[k] = 8'((p * PAGE + k) * 37 + 11);
            write_page(16'hFF00 | 16'(p * PAGE), PAGE, 1'b1, "R5 R8");
        end
        mode3 = 1'b0; read_seq(16'h0000, DEPTH + 2, "R3 R4 R2 mode0");
        mode3 = 1'b1; read_seq(16'hC039, 10, "R3 R4 R2 mode3");

        // R5: page offset wrap and overflow
        wb[0] = 8'hA1; wb[1] = 8'hA2; wb[2] = 8'hA3;
        write_page(16'd22, 3, 1'b1, "R5 wrap");
        for (int k = 0; k < 10; k++) wb[k] = 8'(8'hB0 + k);
        mode3 = 1'b0;
        write_page(16'd40, 10, 1'b1, "R5 overflow");
        read_seq(16'd16, 8, "R5 page2");
        read_seq(16'd40, 8, "R5 page5");

        // R6: partial byte and empty write
        cs_lo(); send(8'h02, "R11"); send(8'h00, "R11"); send(8'h05, "R11");
        send(8'h77, "R11");
        for (int i = 0; i < 3; i++) bit_io(1'b1, r, oe);
        finish_write(len); chk("R6 partial byte busy", len, 0);
        cs_lo(); send(8'h02, "R11"); send(8'h00, "R11"); send(8'h05, "R11");
        finish_write(len); chk("R6 empty write busy", len, 0);
        read_seq(16'd0, 8, "R6 unchanged");

        // R9: permit low
        wr_permit = 1'b0;
        wb[0] = 8'h11; wb[1] = 8'h22;
        write_page(16'd9, 2, 1'b0, "R9");
        wr_permit = 1'b1;
        read_seq(16'd8, 4, "R9 unchanged");

        // R7: status load
        mode3 = 1'b1;
        cs_lo(); send(8'h01, "R11"); send(8'hA5, "R11");
        finish_write(len); chk("R7 R8 status busy", len, WRC); chk("R7 status", status, 8'hA5);
        cs_lo(); send(8'h01, "R11"); send(8'h5A, "R11"); bit_io(1'b1, r, oe);
        finish_write(len); chk("R7 nine bits busy", len, 0); chk("R7 nine bits", status, 8'hA5);
        cs_lo(); send(8'h01, "R11"); send(8'h5A, "R11"); send(8'h5A, "R11");
        finish_write(len); chk("R7 sixteen bits", status, 8'hA5);
        cs_lo(); send(8'h01, "R11");
        for (int i = 0; i < 4; i++) bit_io(1'b0, r, oe);
        finish_write(len); chk("R7 four bits", status, 8'hA5);
        wr_permit = 1'b0;
        cs_lo(); send(8'h01, "R11"); send(8'h3C, "R11");
        finish_write(len); chk("R9 status permit", status, 8'hA5); chk("R9 status busy", len, 0);
        wr_permit = 1'b1;

        // R12: unknown instruction
        cs_lo(); send(8'h05, "R12 oe"); send(8'h00, "R12 oe"); send(8'h2A, "R12 oe");
        send(8'h99, "R12 oe");
        finish_write(len); chk("R12 busy", len, 0);
        cs_lo(); send(8'hFF, "R12 oe"); send(8'h00, "R12 oe");
        finish_write(len); chk("R12 busy ff", len, 0);
        read_seq(16'd40, 3, "R12 unchanged");

        // R8: transactions begun while busy
        cs_lo(); send(8'h02, "R11"); send(8'h00, "R11"); send(8'h1E, "R11"); send(8'h5E, "R11");
        tick(H); cs_n = 1'b1; tick(8);
        chk("R8 busy after commit", busy, 1);
        model[30] = 8'h5E;
        cs_n = 1'b0; tick(H);
        send(8'h02, "R8 oe"); send(8'h00, "R8 oe"); send(8'h1E, "R8 oe"); send(8'h99, "R8 oe");
        tick(H); cs_n = 1'b1; len = 0;
        for (int w = 0; w < 20; w++) begin if (busy) len++; tick(1); end
        chk("R8 ignored write busy", len, 0);
        read_seq(16'd30, 1, "R8 ignored write");
        cs_lo(); send(8'h02, "R11"); send(8'h00, "R11"); send(8'h1F, "R11"); send(8'h6F, "R11");
        tick(H); cs_n = 1'b1; tick(8);
        model[31] = 8'h6F;
        cs_n = 1'b0; tick(H);
        send(8'h03, "R8 oe"); send(8'h00, "R8 oe"); send(8'h1F, "R8 oe"); send(8'h00, "R8 read oe");
        cs_hi();
        read_seq(16'd30, 2, "R8 after busy");

        // R10: pause during read and during write
        mode3 = 1'b0;
        cs_lo(); send(8'h03, "R11"); send(8'h00, "R11"); send(8'h0A, "R11");
        for (int i = 0; i < 8; i++) begin
            if (i == 3) pause();
            bit_io(1'b0, rx[7-i], oe);
        end
        chk("R10 read resumes", rx, model[10]);
        xfer(8'h00, rx, oev);
        chk("R10 next byte", rx, model[11]);
        cs_hi();
        cs_lo(); send(8'h02, "R11"); send(8'h00, "R11"); send(8'h2A, "R11");
        wb[0] = 8'hC3;
        for (int i = 0; i < 8; i++) begin
            if (i == 5) pause();
            bit_io(wb[0][7-i], r, oe);
        end
        finish_write(len); chk("R10 write busy", len, WRC);
        model[42] = 8'hC3;
        read_seq(16'd42, 1, "R10 write resumes");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule